// File: doc/BRIEF.md
# Pixel Component Extractor

This block sits between a framebuffer byte stream and a display output. Bytes arrive one per cycle on a valid/ready handshake and collect in a small buffer. On every cycle where the display marks an active pixel, the block takes one pixel's worth of bytes from the buffer and builds a pixel word. It then cuts a red, a green and a blue field out of that word and widens each field to 8 bits.

A format input tells the block how many bytes make up one pixel. Three select inputs, one per colour, give each field's lowest bit, its length and a fallback value. The fallback value is used when a field has length zero, when the pixel lies outside the active area, or when the buffer does not hold enough bytes for a full pixel. The outputs are registered. Data-enable and the two sync signals pass through the same one-cycle delay, so they stay aligned with the colour values.

Top module: `pxl_comp_extract`

## Requirements
- R1: Bits [4:3] of `fmt_cfg` hold the pixel size in bytes minus one, so the values 0..3 select 1..4 bytes per pixel. Each active pixel consumes exactly that many bytes.
- R2: Pixel bytes are assembled little-endian: the oldest buffered byte forms bits [7:0] of the pixel word, the next byte forms bits [15:8], and so on. Bytes beyond the pixel size read as zero.
- R3: Bits [4:0] of each colour select input give the bit index of that field's least significant bit within the pixel word.
- R4: Bits [11:8] of each colour select input give the field length. A length of zero makes that colour output its fallback value.
- R5: Bits [23:16] of each colour select input hold that colour's 8-bit fallback value.
- R6: A field shorter than 8 bits is placed at the top of the 8-bit output. Its bits are then repeated from the top downwards into the vacant low bits.
- R7: A field length above 8 is clamped to 8 bits, and the output is the 8 most significant bits of the field.
- R8: While `de_in` is low, all three colours output their fallback values and no buffered byte is consumed.
- R9: When `de_in` is high and fewer bytes are buffered than one pixel needs, all three colours output their fallback values, `urun_o` is raised with `de_o`, and no byte is consumed.
- R10: The colour outputs, `de_o`, `hs_o`, `vs_o` and `urun_o` are registered. Each reflects its inputs from the previous clock cycle.
- R11: After reset the outputs are zero and the buffer is empty. `byte_rdy` is high exactly when the buffer holds fewer than `BUF_BYTES` bytes, and a byte offered while it is low is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_cfg | input | 32 | Pixel size field at [4:3] |
| sel_red | input | 32 | Red select: fallback [23:16], length [11:8], offset [4:0] |
| sel_grn | input | 32 | Green select, same layout |
| sel_blu | input | 32 | Blue select, same layout |
| byte_vld | input | 1 | Input byte valid |
| byte_dat | input | 8 | Input byte |
| byte_rdy | output | 1 | Buffer can accept a byte |
| de_in | input | 1 | Active-pixel strobe |
| hs_in | input | 1 | Horizontal sync in |
| vs_in | input | 1 | Vertical sync in |
| red_o | output | 8 | Red component |
| grn_o | output | 8 | Green component |
| blu_o | output | 8 | Blue component |
| de_o | output | 1 | Delayed active-pixel strobe |
| hs_o | output | 1 | Delayed horizontal sync |
| vs_o | output | 1 | Delayed vertical sync |
| urun_o | output | 1 | Pixel was replaced because bytes were missing |

## Verification
Some properties are checked on every cycle. Blanked output carries the fallback values of the previous cycle. The underrun flag only appears together with `de_o`, and the sync outputs follow their inputs one cycle later. The buffer never releases more bytes than it holds and never grows while it is full. Other behaviour can only be shown by the bench's scenarios, which model the byte buffer on their own: that the right bytes make up each pixel across all four pixel sizes, the field cutting with bit repetition and clamping, a zero length, and the fact that blanked or underrun cycles leave the buffer untouched.

// File: rtl/pce_pkg.sv
package pce_pkg;

  localparam int PCE_MAX_BYTES = 4;
  localparam int PCE_WORD_W    = 8 * PCE_MAX_BYTES;

  // Keep only the bytes that belong to the current pixel size.
  function automatic logic [PCE_WORD_W-1:0] pce_assemble(
    input logic [PCE_WORD_W-1:0] raw,
    input logic [1:0]            size_m1
  );
    logic [PCE_WORD_W-1:0] w;
    w = '0;
    for (int b = 0; b < PCE_MAX_BYTES; b++) begin
      if (b <= int'(size_m1)) w[8*b +: 8] = raw[8*b +: 8];
    end
    return w;
  endfunction

  // Cut a field and widen it to 8 bits, repeating short fields downwards.
  function automatic logic [7:0] pce_extract(
    input logic [PCE_WORD_W-1:0] word,
    input logic [4:0]            lsb,
    input logic [3:0]            len
  );
    logic [PCE_WORD_W-1:0] fld;
    logic [7:0]            res;
    int eff, base, j;
    res = '0;
    if (len != 4'd0) begin
      fld  = word >> lsb;
      eff  = (int'(len) > 8) ? 8 : int'(len);
      base = int'(len) - eff;
      j    = eff - 1;
      for (int k = 7; k >= 0; k--) begin
        res[k] = fld[base + j];
        j      = (j == 0) ? eff - 1 : j - 1;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/pce_byte_fifo.sv
module pce_byte_fifo #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_vld,
  input  logic [7:0]    push_byte,
  output logic          push_rdy,
  input  logic [2:0]    pop_n,
  output logic [31:0]   head,
  output logic [CW-1:0] level
);

  logic [7:0]    mem [DEPTH];
  logic [7:0]    nxt [DEPTH];
  logic [CW-1:0] cnt;
  logic          do_push;

  assign push_rdy = (int'(cnt) < DEPTH);
  assign do_push  = push_vld && push_rdy;
  assign level    = cnt;
  assign head     = {mem[3], mem[2], mem[1], mem[0]};

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (i + int'(pop_n) < DEPTH) nxt[i] = mem[i + int'(pop_n)];
      else                         nxt[i] = 8'h00;
    end
    if (do_push) nxt[int'(cnt) - int'(pop_n)] = push_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else begin
      cnt <= cnt - CW'(pop_n) + CW'(do_push);
      for (int i = 0; i < DEPTH; i++) mem[i] <= nxt[i];
    end
  end

  AST_POP_WITHIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop_n) <= int'(cnt)); // R9

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(int'(cnt)) == DEPTH && $past(pop_n) == 3'd0) |-> int'(cnt) == DEPTH); // R11

endmodule

// File: rtl/pce_field_unit.sv
module pce_field_unit
  import pce_pkg::*;
(
  input  logic [PCE_WORD_W-1:0] word,
  input  logic [31:0]           sel,
  input  logic                  blank,
  output logic [7:0]            comp
);

  logic [4:0] lsb;
  logic [3:0] len;
  logic [7:0] dflt;
  logic       unused_sel_bits;

  assign lsb  = sel[4:0];
  assign len  = sel[11:8];
  assign dflt = sel[23:16];
  assign unused_sel_bits = ^{sel[31:24], sel[15:12], sel[7:5]};

  assign comp = (blank || len == 4'd0) ? dflt : pce_extract(word, lsb, len);

endmodule

// File: rtl/pxl_comp_extract.sv
module pxl_comp_extract
  import pce_pkg::*;
#(
  parameter int BUF_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] fmt_cfg,
  input  logic [31:0] sel_red,
  input  logic [31:0] sel_grn,
  input  logic [31:0] sel_blu,
  input  logic        byte_vld,
  input  logic [7:0]  byte_dat,
  output logic        byte_rdy,
  input  logic        de_in,
  input  logic        hs_in,
  input  logic        vs_in,
  output logic [7:0]  red_o,
  output logic [7:0]  grn_o,
  output logic [7:0]  blu_o,
  output logic        de_o,
  output logic        hs_o,
  output logic        vs_o,
  output logic        urun_o
);

  localparam int LW = $clog2(BUF_BYTES + 1);

  logic [1:0]            size_m1;
  logic [2:0]            need;
  logic [LW-1:0]         level;
  logic [31:0]           head;
  logic [PCE_WORD_W-1:0] word;
  logic                  avail, take, underrun;
  logic [2:0]            pop_n;
  logic [31:0]           sel_arr [3];
  logic [7:0]            comp    [3];
  logic                  live_q;
  logic                  unused_fmt_bits;

  assign size_m1  = fmt_cfg[4:3];
  assign need     = {1'b0, size_m1} + 3'd1;
  assign unused_fmt_bits = ^{fmt_cfg[31:5], fmt_cfg[2:0]};

  // Internal events, named for the checks below.
  assign avail    = (int'(level) >= int'(need));
  assign take     = de_in && avail;
  assign underrun = de_in && !avail;
  assign pop_n    = take ? need : 3'd0;

  pce_byte_fifo #(.DEPTH(BUF_BYTES)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_vld  (byte_vld),
    .push_byte (byte_dat),
    .push_rdy  (byte_rdy),
    .pop_n     (pop_n),
    .head      (head),
    .level     (level)
  );

  assign word = pce_assemble(head, size_m1);

  assign sel_arr[0] = sel_red;
  assign sel_arr[1] = sel_grn;
  assign sel_arr[2] = sel_blu;

  for (genvar c = 0; c < 3; c++) begin : g_comp
    pce_field_unit u_field (
      .word  (word),
      .sel   (sel_arr[c]),
      .blank (!take),
      .comp  (comp[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      red_o  <= 8'h00;
      grn_o  <= 8'h00;
      blu_o  <= 8'h00;
      de_o   <= 1'b0;
      hs_o   <= 1'b0;
      vs_o   <= 1'b0;
      urun_o <= 1'b0;
      live_q <= 1'b0;
    end else begin
      red_o  <= comp[0];
      grn_o  <= comp[1];
      blu_o  <= comp[2];
      de_o   <= de_in;
      hs_o   <= hs_in;
      vs_o   <= vs_in;
      urun_o <= underrun;
      live_q <= 1'b1;
    end
  end

  AST_BLANK_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !de_o) |-> (red_o == $past(sel_red[23:16]) && grn_o == $past(sel_grn[23:16])
                           && blu_o == $past(sel_blu[23:16]))); // R8

  AST_URUN_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    urun_o |-> de_o); // R9

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (hs_o == $past(hs_in) && vs_o == $past(vs_in) && de_o == $past(de_in))); // R10

  AST_NO_TAKE_WHEN_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (de_in && int'(level) < int'(need)) |=> urun_o); // R9

endmodule

// File: tb/pxl_comp_extract_tb_top.sv
module pxl_comp_extract_tb_top;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fmt_cfg = '0, sel_red = '0, sel_grn = '0, sel_blu = '0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_dat = '0;
  logic        byte_rdy;
  logic        de_in = 1'b0, hs_in = 1'b0, vs_in = 1'b0;
  logic [7:0]  red_o, grn_o, blu_o;
  logic        de_o, hs_o, vs_o, urun_o;

  int total = 0;
  int bad   = 0;

  logic [7:0]  model_q[$];
  logic [30:0] exp_q[$];   // {urun, vs, hs, de, r, g, b} packed below
  string       tag_q[$];

  always #4 clk = ~clk;

  pxl_comp_extract #(.BUF_BYTES(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_cfg(fmt_cfg),
    .sel_red(sel_red), .sel_grn(sel_grn), .sel_blu(sel_blu),
    .byte_vld(byte_vld), .byte_dat(byte_dat), .byte_rdy(byte_rdy),
    .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in),
    .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o),
    .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o), .urun_o(urun_o)
  );

  function automatic logic [7:0] ref_comp(input logic [31:0] word, input logic [31:0] sel);
    int len, off;
    logic [31:0] fld, tmp, acc;
    len = int'(sel[11:8]);
    off = int'(sel[4:0]);
    if (len == 0) return sel[23:16];
    fld = word >> off;
    if (len >= 8) return 8'((fld >> (len - 8)) & 32'hFF);
    tmp = ((fld & ((32'd1 << len) - 1)) << (8 - len));
    acc = tmp;
    for (int s = len; s < 8; s += len) acc = acc | (tmp >> s);
    return acc[7:0];
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, with the expected output pushed after the edge.
  task automatic step(input logic de, input logic hs, input logic vs,
                      input logic pv, input logic [7:0] pb, input string tag);
    int need;
    logic [31:0] word;
    logic [7:0] er, eg, eb;
    logic eu;
    bit rdy;
    de_in = de; hs_in = hs; vs_in = vs; byte_vld = pv; byte_dat = pb;
    need = int'(fmt_cfg[4:3]) + 1;
    rdy  = (model_q.size() < DEPTH);
    er = sel_red[23:16]; eg = sel_grn[23:16]; eb = sel_blu[23:16]; eu = 1'b0;
    if (de) begin
      if (model_q.size() >= need) begin
        word = '0;
        for (int i = 0; i < need; i++) word = word | (32'(model_q[i]) << (8 * i));
        for (int i = 0; i < need; i++) void'(model_q.pop_front());
        er = ref_comp(word, sel_red);
        eg = ref_comp(word, sel_grn);
        eb = ref_comp(word, sel_blu);
      end else begin
        eu = 1'b1;
      end
    end
    if (pv && rdy) model_q.push_back(pb);
    @(posedge clk);
    exp_q.push_back({3'b000, eu, vs, hs, de, er, eg, eb});
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // Monitor: compares one result per cycle, away from the active edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [30:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {33'd0, 3'b000, urun_o, vs_o, hs_o, de_o, red_o, grn_o, blu_o}, {33'd0, e});
    end
  end

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic push_bytes(input logic [7:0] b0, input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b1, 8'(b0 + 8'(i * 37)), tag);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R11: reset state
    check("R11 reset outputs", {40'd0, red_o, grn_o, blu_o}, 64'd0);
    check("R11 reset flags", {60'd0, de_o, hs_o, vs_o, urun_o}, 64'd0);
    check("R11 reset ready", {63'd0, byte_rdy}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R5: three bytes per pixel, 8-bit fields; R8 fallback while blanked
    fmt_cfg = 32'h0000_0010;
    sel_red = 32'h00A1_0810; sel_grn = 32'h00B2_0808; sel_blu = 32'h00C3_0800;
    push_bytes(8'h11, 6, "R8 blank fallback while filling");
    step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R2 little-endian 3-byte pixel");
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R10 sync delay blank");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R3 offsets 16/8/0");

    // R6: two bytes per pixel, 5/6/5 fields with bit repetition
    fmt_cfg = 32'h0000_0008;
    sel_red = 32'h0000_050B; sel_grn = 32'h0000_0605; sel_blu = 32'h0000_0500;
    push_bytes(8'hF3, 4, "R8 blank fill 565");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R6 short fields replicated");
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R6 second 565 pixel");

    // R4 R5: one byte per pixel, zero-length blue uses fallback
    fmt_cfg = 32'h0000_0000;
    sel_red = 32'h0000_0305; sel_grn = 32'h0000_0302; sel_blu = 32'h005A_0003;
    push_bytes(8'hC9, 3, "R8 blank fill 1bpp");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R4 zero length fallback");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R1 one byte per pixel");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R5 fallback value");

    // R7: four bytes per pixel, 10-bit field clamped
    fmt_cfg = 32'h0000_0018;
    sel_red = 32'h0000_0A14; sel_grn = 32'h0000_0F03; sel_blu = 32'h0000_0100;
    push_bytes(8'h5D, 4, "R8 blank fill 4bpp");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R7 clamp to top 8 bits");

    // R9: underrun keeps the bytes, next pixel uses them
    fmt_cfg = 32'h0000_0010;
    sel_red = 32'h0011_0810; sel_grn = 32'h0022_0808; sel_blu = 32'h0033_0800;
    push_bytes(8'h40, 2, "R8 blank partial fill");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R9 underrun fallback and flag");
    step(1'b1, 1'b0, 1'b0, 1'b1, 8'h99, "R9 underrun while byte arrives");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R9 bytes kept after underrun");

    // R11: full buffer refuses bytes
    fmt_cfg = 32'h0000_0018;
    push_bytes(8'h07, DEPTH + 2, "R11 fill past depth");
    check("R11 ready low when full", {63'd0, byte_rdy}, 64'd0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R11 drain first word");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R11 rejected bytes not stored");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R9 empty after drain");
    check("R11 ready after drain", {63'd0, byte_rdy}, 64'd1);

    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R10 final flush");
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule